// File: doc/BRIEF.md
# Time-Slot Switch Output Stage

This block builds eight serial time-division output streams. It takes their content from an on-block connection store with 256 entries. Each entry has a byte part and a three-bit control part. For every output channel, the entry selects the source of the byte. The byte may be switched from a data memory, with the byte part used as the data memory address. Or the byte part may be transmitted directly as a message. The entry also sets whether the stream drives that time slot at all, and one bit for a separate control stream.

A frame holds 32 channels of 8 bits on each stream. Each bit lasts two clocks. A one-cycle frame pulse restarts the frame. The block fetches the next channel's bytes during the current channel: one data memory read per stream, all through a single asynchronous read port. It loads them into per-stream shifters at the channel boundary. A global drive-enable and a broadcast message flag override the per-entry control bits. Tri-state is shown as a per-stream output enable, and a disabled stream presents logic 1 on its data line.

Top module: `tsw_out_stage`

## Requirements
- R1: When an entry's control bit 2 is 0 (switched), `dm_raddr` presents the entry's byte part during the fetch. The channel then carries the `dm_rdata` byte returned for that address.
- R2: When an entry's control bit 2 is 1 (message), the channel carries the entry's byte part itself. The same byte appears again in every frame while the entry is unchanged.
- R3: Control bit 0 set drives the channel: `ser_oe` is high for all 8 bit cells of the slot. Control bit 0 clear releases the slot: `ser_oe` is low and `ser_data` is 1.
- R4: `ctl_ser` carries the inverse of control bit 1 of the entry for stream s, channel c, in bit cell c*8+s of the 256-cell frame.
- R5: With `bcast_msg` high, every channel acts as if control bits 2 and 0 of its entry were set (message and driven), whatever the stored values.
- R6: With `drive_en` low, every `ser_oe` is low and every `ser_data` is 1 in that same cycle, whatever the entries hold.
- R7: Each bit cell lasts two clocks. Channel c occupies bit cells c*8 to c*8+7, most significant bit first, and the frame of 256 cells wraps.
- R8: A high `fsync` at a clock edge makes the next cycle the first clock of bit cell 0 of channel 0.
- R9: Out of reset, every `ser_oe` is low, every `ser_data` is 1 and `ctl_ser` is 1.
- R10: The entry for stream s, channel c is at address s*32+c. A rewrite of an entry is fully visible in the frame after the one in which it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, two per bit cell |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame restart pulse |
| drive_en | input | 1 | Global enable of all stream drivers |
| bcast_msg | input | 1 | Force every channel to driven message mode |
| cm_we_lo | input | 1 | Write strobe for the entry byte part |
| cm_we_hi | input | 1 | Write strobe for the entry control part (data bits 2:0) |
| cm_waddr | input | 8 | Entry address, stream*32+channel |
| cm_wdata | input | 8 | Entry write data |
| dm_raddr | output | 8 | Data memory read address |
| dm_rdata | input | 8 | Data memory read data, same cycle as the address |
| ser_data | output | 8 | Serial data, one bit per stream |
| ser_oe | output | 8 | Output enable, one bit per stream |
| ctl_ser | output | 1 | Inverted control-bit serial stream |

## Verification
The bench fills all 256 entries with address-dependent byte and control patterns and compares whole captured frames. A per-address byte pattern shows whether entries are misplaced across streams or channels. The data memory model returns the address XOR 0xA5, so switched and message channels can never show the same byte. Mixed control patterns, with every combination of the three bits, show whether one bit leaks into another: message against switched, driven against released, and the polarity and slot order of the control stream. Further frames are run with broadcast set, with drive-enable low, after a single entry is rewritten, and after a frame pulse in mid-frame, to show that the overrides, the repetition and the realignment act as stated.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
   // control-part layout of a connection entry
   localparam int CMH_W   = 3;
   localparam int MSG_BIT = 2;
   localparam int CTL_BIT = 1;
   localparam int OE_BIT  = 0;
endpackage

// File: rtl/tsw_frame_timer.sv
module tsw_frame_timer #(
   parameter  int N_CHANS = 32,
   parameter  int BYTE_W  = 8,
   parameter  int CPB     = 2,
   localparam int PH_W    = $clog2(BYTE_W*CPB),
   localparam int CH_W    = $clog2(N_CHANS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fsync,
   output logic [PH_W-1:0] phase,
   output logic [CH_W-1:0] chan,
   output logic            bit_tick,
   output logic            load_tick
);
   localparam int CNT_W = PH_W + CH_W;
   localparam int CPB_W = $clog2(CPB);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (fsync) cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end

   assign phase     = cnt[PH_W-1:0];
   assign chan      = cnt[CNT_W-1:PH_W];
   assign load_tick = fsync | (phase == '1);
   assign bit_tick  = (cnt[CPB_W-1:0] == '1) & ~load_tick;
endmodule

// File: rtl/tsw_fetch.sv
module tsw_fetch
   import tsw_pkg::*;
#(
   parameter  int N_STREAMS = 8,
   parameter  int N_CHANS   = 32,
   parameter  int BYTE_W    = 8,
   parameter  int PH_W      = 4,
   localparam int SW        = $clog2(N_STREAMS),
   localparam int CH_W      = $clog2(N_CHANS),
   localparam int AW        = SW + CH_W,
   localparam int DEPTH     = N_STREAMS * N_CHANS
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [PH_W-1:0]                    phase,
   input  logic [CH_W-1:0]                    chan,
   input  logic                               bcast_msg,
   input  logic                               cm_we_lo,
   input  logic                               cm_we_hi,
   input  logic [AW-1:0]                      cm_waddr,
   input  logic [BYTE_W-1:0]                  cm_wdata,
   input  logic [BYTE_W-1:0]                  dm_rdata,
   output logic [BYTE_W-1:0]                  dm_raddr,
   output logic [N_STREAMS-1:0][BYTE_W-1:0]   nxt_byte,
   output logic [N_STREAMS-1:0]               nxt_oe,
   output logic [N_STREAMS-1:0]               nxt_ctl
);
   logic [BYTE_W-1:0] cm_lo [DEPTH];
   logic [CMH_W-1:0]  cm_hi [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            cm_lo[i] <= '0;
            cm_hi[i] <= '0;
         end
      end else begin
         if (cm_we_lo) cm_lo[cm_waddr] <= cm_wdata;
         if (cm_we_hi) cm_hi[cm_waddr] <= cm_wdata[CMH_W-1:0];
      end
   end

   // one stream per clock in the first phases of a channel, for the next channel
   logic [SW-1:0]    sel;
   logic [CH_W-1:0]  nc;
   logic [AW-1:0]    ridx;
   logic             active;
   logic [CMH_W-1:0] hi_r;
   logic             msg_e;
   logic             oe_e;

   assign sel      = phase[SW-1:0];
   assign active   = (phase >> SW) == '0;
   assign nc       = chan + 1'b1;
   assign ridx     = {sel, nc};
   assign hi_r     = cm_hi[ridx];
   assign dm_raddr = cm_lo[ridx];
   assign msg_e    = bcast_msg | hi_r[MSG_BIT];
   assign oe_e     = bcast_msg | hi_r[OE_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nxt_byte <= '1;
         nxt_oe   <= '0;
         nxt_ctl  <= '0;
      end else if (active) begin
         nxt_byte[sel] <= msg_e ? dm_raddr : dm_rdata;
         nxt_oe[sel]   <= oe_e;
         nxt_ctl[sel]  <= hi_r[CTL_BIT];
      end
   end
endmodule

// File: rtl/tsw_serializer.sv
module tsw_serializer #(
   parameter int N_STREAMS = 8,
   parameter int BYTE_W    = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             load,
   input  logic                             shift,
   input  logic                             drive_en,
   input  logic [N_STREAMS-1:0][BYTE_W-1:0] nxt_byte,
   input  logic [N_STREAMS-1:0]             nxt_oe,
   input  logic [N_STREAMS-1:0]             nxt_ctl,
   output logic [N_STREAMS-1:0]             ser_data,
   output logic [N_STREAMS-1:0]             ser_oe,
   output logic                             ctl_ser
);
   for (genvar s = 0; s < N_STREAMS; s++) begin : g_lane
      logic [BYTE_W-1:0] sr;
      logic              oe_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sr   <= '1;
            oe_q <= 1'b0;
         end else if (load) begin
            sr   <= nxt_byte[s];
            oe_q <= nxt_oe[s];
         end else if (shift) begin
            sr   <= {sr[BYTE_W-2:0], 1'b1};
         end
      end

      assign ser_oe[s]   = drive_en & oe_q;
      assign ser_data[s] = ser_oe[s] ? sr[BYTE_W-1] : 1'b1;
   end

   // control bits leave stream 0 first, inverted
   logic [N_STREAMS-1:0] ctl_sr;
   always_ff @(posedge clk) begin
      if (!rst_n)     ctl_sr <= '0;
      else if (load)  ctl_sr <= nxt_ctl;
      else if (shift) ctl_sr <= {1'b0, ctl_sr[N_STREAMS-1:1]};
   end
   assign ctl_ser = ~ctl_sr[0];
endmodule

// File: rtl/tsw_out_stage.sv
module tsw_out_stage #(
   parameter  int N_STREAMS = 8,
   parameter  int N_CHANS   = 32,
   parameter  int BYTE_W    = 8,
   parameter  int CPB       = 2,
   localparam int AW        = $clog2(N_STREAMS*N_CHANS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fsync,
   input  logic                 drive_en,
   input  logic                 bcast_msg,
   input  logic                 cm_we_lo,
   input  logic                 cm_we_hi,
   input  logic [AW-1:0]        cm_waddr,
   input  logic [BYTE_W-1:0]    cm_wdata,
   output logic [BYTE_W-1:0]    dm_raddr,
   input  logic [BYTE_W-1:0]    dm_rdata,
   output logic [N_STREAMS-1:0] ser_data,
   output logic [N_STREAMS-1:0] ser_oe,
   output logic                 ctl_ser
);
   localparam int PH_W = $clog2(BYTE_W*CPB);
   localparam int CH_W = $clog2(N_CHANS);

   if (N_STREAMS != BYTE_W) begin : g_bad_lanes
      $error("control stream needs one bit cell per stream");
   end
   if (AW != BYTE_W) begin : g_bad_addr
      $error("entry byte must span the data memory address");
   end
   if (CPB < 2 || (1 << $clog2(CPB)) != CPB) begin : g_bad_cpb
      $error("clocks per bit must be a power of two, at least 2");
   end
   if ((1 << CH_W) != N_CHANS || (1 << $clog2(N_STREAMS)) != N_STREAMS) begin : g_bad_pow
      $error("stream and channel counts must be powers of two");
   end
   if (N_STREAMS > BYTE_W*CPB) begin : g_bad_fetch
      $error("not enough clocks per channel to prefetch every stream");
   end

   logic [PH_W-1:0]                  phase;
   logic [CH_W-1:0]                  chan;
   logic                             bit_tick;
   logic                             load_tick;
   logic [N_STREAMS-1:0][BYTE_W-1:0] nxt_byte;
   logic [N_STREAMS-1:0]             nxt_oe;
   logic [N_STREAMS-1:0]             nxt_ctl;

   tsw_frame_timer #(.N_CHANS(N_CHANS), .BYTE_W(BYTE_W), .CPB(CPB)) u_tmr (
      .clk(clk), .rst_n(rst_n), .fsync(fsync),
      .phase(phase), .chan(chan), .bit_tick(bit_tick), .load_tick(load_tick)
   );

   tsw_fetch #(.N_STREAMS(N_STREAMS), .N_CHANS(N_CHANS), .BYTE_W(BYTE_W), .PH_W(PH_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .phase(phase), .chan(chan), .bcast_msg(bcast_msg),
      .cm_we_lo(cm_we_lo), .cm_we_hi(cm_we_hi), .cm_waddr(cm_waddr), .cm_wdata(cm_wdata),
      .dm_rdata(dm_rdata), .dm_raddr(dm_raddr),
      .nxt_byte(nxt_byte), .nxt_oe(nxt_oe), .nxt_ctl(nxt_ctl)
   );

   tsw_serializer #(.N_STREAMS(N_STREAMS), .BYTE_W(BYTE_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .load(load_tick), .shift(bit_tick), .drive_en(drive_en),
      .nxt_byte(nxt_byte), .nxt_oe(nxt_oe), .nxt_ctl(nxt_ctl),
      .ser_data(ser_data), .ser_oe(ser_oe), .ctl_ser(ctl_ser)
   );
endmodule

// File: rtl/tsw_out_chk.sv
module tsw_out_chk #(
   parameter int N_STREAMS = 8,
   parameter int PH_W      = 4,
   parameter int CH_W      = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 fsync,
   input logic                 drive_en,
   input logic [N_STREAMS-1:0] ser_data,
   input logic [N_STREAMS-1:0] ser_oe,
   input logic                 ctl_ser,
   input logic                 bit_tick,
   input logic                 load_tick,
   input logic [PH_W-1:0]      phase,
   input logic [CH_W-1:0]      chan
);
   // R7
   cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_tick && !load_tick) |=> ($stable(ser_data) || !$stable(drive_en)));

   // R4
   ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_tick && !load_tick) |=> $stable(ctl_ser));

   // R3
   slot_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_tick |=> ($stable(ser_oe) || !$stable(drive_en)));

   // R8
   frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |=> (phase == '0 && chan == '0));
endmodule

bind tsw_out_stage tsw_out_chk #(
   .N_STREAMS(N_STREAMS), .PH_W($clog2(BYTE_W*CPB)), .CH_W($clog2(N_CHANS))
) u_chk (
   .clk(clk), .rst_n(rst_n), .fsync(fsync), .drive_en(drive_en),
   .ser_data(ser_data), .ser_oe(ser_oe), .ctl_ser(ctl_ser),
   .bit_tick(u_tmr.bit_tick), .load_tick(u_tmr.load_tick),
   .phase(u_tmr.phase), .chan(u_tmr.chan)
);

// File: tb/sim_tsw_out_stage.sv
`timescale 1ns/1ps
module sim_tsw_out_stage;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fsync = 1'b0;
   logic       drive_en = 1'b1;
   logic       bcast_msg = 1'b0;
   logic       cm_we_lo = 1'b0;
   logic       cm_we_hi = 1'b0;
   logic [7:0] cm_waddr = '0;
   logic [7:0] cm_wdata = '0;
   logic [7:0] dm_raddr;
   logic [7:0] dm_rdata;
   logic [7:0] ser_data;
   logic [7:0] ser_oe;
   logic       ctl_ser;

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   always #2 clk = ~clk;

   // data memory model: byte = address ^ A5
   assign dm_rdata = dm_raddr ^ 8'hA5;

   tsw_out_stage u0 (
      .clk(clk), .rst_n(rst_n), .fsync(fsync), .drive_en(drive_en), .bcast_msg(bcast_msg),
      .cm_we_lo(cm_we_lo), .cm_we_hi(cm_we_hi), .cm_waddr(cm_waddr), .cm_wdata(cm_wdata),
      .dm_raddr(dm_raddr), .dm_rdata(dm_rdata),
      .ser_data(ser_data), .ser_oe(ser_oe), .ctl_ser(ctl_ser)
   );

   // frame position from the requirements: 512 clocks, restarted by fsync
   logic [8:0] pos = '0;
   always @(posedge clk) begin
      if (!rst_n || fsync) pos <= '0;
      else                 pos <= pos + 1'b1;
   end

   logic [7:0] sh_lo [256];
   logic [2:0] sh_hi [256];
   logic [7:0] cap_d  [256];
   logic [7:0] cap_oe [256];
   logic       cap_c  [256];

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr_lo(input int a, input logic [7:0] d);
      @(negedge clk);
      cm_waddr = a[7:0]; cm_wdata = d; cm_we_lo = 1'b1;
      @(negedge clk);
      cm_we_lo = 1'b0;
      sh_lo[a] = d;
   endtask

   task automatic wr_hi(input int a, input logic [2:0] d);
      @(negedge clk);
      cm_waddr = a[7:0]; cm_wdata = {5'b0, d}; cm_we_hi = 1'b1;
      @(negedge clk);
      cm_we_hi = 1'b0;
      sh_hi[a] = d;
   endtask

   task automatic capture();
      @(negedge clk);
      while (pos != 0) @(negedge clk);
      for (int k = 0; k < 512; k++) begin
         if (k % 2 == 1) begin
            cap_d[k/2]  = ser_data;
            cap_oe[k/2] = ser_oe;
            cap_c[k/2]  = ctl_ser;
         end
         @(negedge clk);
      end
   endtask

   // R1 R2 R3 R4 R5 R6 R7 R10: compare a captured frame with the model
   task automatic check_frame(input string req);
      for (int s = 0; s < 8; s++) begin
         for (int c = 0; c < 32; c++) begin
            int         idx;
            logic       eoe, emsg;
            logic [7:0] eb, gb, goe;
            idx  = s*32 + c;
            eoe  = drive_en & (bcast_msg | sh_hi[idx][0]);
            emsg = bcast_msg | sh_hi[idx][2];
            eb   = !eoe ? 8'hFF : (emsg ? sh_lo[idx] : (sh_lo[idx] ^ 8'hA5));
            for (int b = 0; b < 8; b++) begin
               gb[7-b]  = cap_d[c*8+b][s];
               goe[7-b] = cap_oe[c*8+b][s];
            end
            chk(gb == eb && goe == {8{eoe}}, req, $sformatf("stream %0d chan %0d byte/oe", s, c),
                {goe, gb}, {{8{eoe}}, eb});
            chk(cap_c[c*8+s] == ~sh_hi[idx][1], "R4", $sformatf("ctl cell %0d", c*8+s),
                int'(cap_c[c*8+s]), int'(~sh_hi[idx][1]));
         end
      end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(ser_oe == 8'h00 && ser_data == 8'hFF && ctl_ser == 1'b1, "R9", "reset outputs",
          {ser_oe, ser_data, 7'b0, ctl_ser}, {8'h00, 8'hFF, 8'h01});
   endtask

   task automatic t_switched();
      for (int i = 0; i < 256; i++) begin
         wr_lo(i, 8'(i*7 + 3));
         wr_hi(i, 3'b001);
      end
      capture();
      capture();
      check_frame("R1/R7/R10 switched");
   endtask

   task automatic t_mixed();
      for (int i = 0; i < 256; i++) wr_hi(i, 3'((i + i/32) % 8));
      capture();
      capture();
      check_frame("R2/R3/R4 mixed");
   endtask

   task automatic t_repeat();
      capture();
      check_frame("R2 repeat");
      wr_hi(5*32 + 31, 3'b101);
      wr_lo(5*32 + 31, 8'h3C);
      capture();
      capture();
      check_frame("R10 rewrite");
      chk(sh_lo[191] == 8'h3C, "R10", "entry 191 rewritten", sh_lo[191], 8'h3C);
   endtask

   task automatic t_bcast();
      @(negedge clk) bcast_msg = 1'b1;
      capture();
      capture();
      check_frame("R5 broadcast");
      @(negedge clk) bcast_msg = 1'b0;
   endtask

   task automatic t_drive();
      @(negedge clk) drive_en = 1'b0;
      #0.5;
      chk(ser_oe == 8'h00 && ser_data == 8'hFF, "R6", "immediate release",
          {ser_oe, ser_data}, 16'h00FF);
      capture();
      check_frame("R6 drive off");
      @(negedge clk) drive_en = 1'b1;
   endtask

   task automatic t_fsync();
      repeat (77) @(negedge clk);
      fsync = 1'b1;
      @(negedge clk);
      fsync = 1'b0;
      chk(pos == 0, "R8", "bench frame restart", pos, 0);
      capture();
      capture();
      check_frame("R8 realigned");
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         sh_lo[i] = '0;
         sh_hi[i] = '0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      @(negedge clk) fsync = 1'b1;
      @(negedge clk) fsync = 1'b0;
      t_switched();
      t_mixed();
      t_repeat();
      t_bcast();
      t_drive();
      t_fsync();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule